// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a small register port. A slow tick, nominally 32000 per second, passes first through a power-of-two prescaler. The prescaler output decrements a 16-bit counter that software loads. When the counter runs out, the block performs a configurable action. Software must rewrite the timeout before that happens.

The block has two stages. The first expiry records an overflow, performs the first-stage action and reloads the counter. If software still does not service the watchdog, the next expiry performs the second-stage action. The counter then halts until the timeout is written again. Each stage has its own action code: nothing, interrupt, SMI or system reset. Sticky flags record which actions have fired, and they are cleared through the status register.

Software can also switch off the slow tick through the configuration register. While it is off, the counter and the prescaler are frozen.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, all three registers read 0, address 3 reads 0, and `irq_o`, `smi_o`, `sys_rst_o` and `slow_clk_off_o` are low.
- R2: A write to the timeout register (address 0) stores the value, loads the counter and restarts at stage one. A stored value of 0 keeps the watchdog idle, so no expiry occurs.
- R3: The counter decrements once every 2^P gated ticks, where P is configuration bits [3:0]. A timeout of N therefore expires on the N·2^P-th tick after the load.
- R4: A prescaler value of 14 or 15 written to the configuration register (address 1) is stored and read back as 13.
- R5: Configuration bits [15:8] read back as written. While bit 8 is set, ticks are ignored and the prescaler and counter hold their values. `slow_clk_off_o` follows bit 8.
- R6: The first expiry sets status bit 0 (overflow) and performs the action in configuration bits [5:4]. The action codes are: 00 none, 01 interrupt (sets status bit 1), 10 SMI (sets status bit 2) and 11 reset (sets status bit 3).
- R7: A second expiry without a timeout write performs the action in configuration bits [7:6] with the same encoding, and leaves status bit 0 untouched. After it, the counter stops until the next timeout write.
- R8: `irq_o` equals status bit 1 and `smi_o` equals status bit 2, both as levels. `sys_rst_o` is high for exactly one cycle after each expiry whose action is reset.
- R9: Status writes (address 2) work as follows. Writing 1 in bit 0 clears only the overflow flag. Writing 0 in bit 0 clears only flags 1 to 3. Status bits [7:4] always read 0.
- R10: When an expiry and a status write fall in the same cycle, the flags set by the expiry win over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_in | input | 1 | One-cycle enable pulse from the slow tick source |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 timeout, 1 configuration, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Interrupt level |
| smi_o | output | 1 | SMI level |
| sys_rst_o | output | 1 | One-cycle system reset request |
| slow_clk_off_o | output | 1 | Power-down request for the slow tick source |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and a prescaler limit of 13. It raises `tick_in` on every clock and uses timeouts of a few counts with prescaler values of 0 and 2, so both stages and the halt after the second stage fall within a few dozen cycles. The upper end of the prescaler range is reached through the clamp readback of 14 and 15 rather than by counting. A behavioural model follows the tick, expiry and flag rules on every clock, which also covers the cycle where an expiry meets a status write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int ADDR_W      = 2;
    localparam int DATA_W      = 16;
    localparam int FLAG_W      = 4;

    localparam int ADDR_TIMEOUT = 0;
    localparam int ADDR_CONFIG  = 1;
    localparam int ADDR_STATUS  = 2;

    // status flag positions
    localparam int FLAG_OVF = 0;
    localparam int FLAG_IRQ = 1;
    localparam int FLAG_SMI = 2;
    localparam int FLAG_RST = 3;

    // configuration field positions
    localparam int CFG_PRES_LO = 0;
    localparam int CFG_ACT1_LO = 4;
    localparam int CFG_ACT2_LO = 6;
    localparam int CFG_PD_BIT  = 8;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_IRQ  = 2'b01,
        ACT_SMI  = 2'b10,
        ACT_RST  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ONE   = 2'b01,
        ST_TWO   = 2'b10,
        ST_DONE  = 2'b11
    } stage_e;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
    parameter int PRES_MAX = 13,
    parameter int PRES_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              restart,
    input  logic [PRES_W-1:0] pres,
    output logic              strobe
);

    localparam int PRE_W = (PRES_MAX < 1) ? 1 : PRES_MAX;
    localparam logic [PRE_W:0]   ONE_W = (PRE_W + 1)'(1);
    localparam logic [PRE_W-1:0] INC   = PRE_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PRE_W:0] mask;

    always_comb begin
        mask   = (ONE_W << pres) - ONE_W;
        strobe = tick_en && ({1'b0, st_q.pre} >= mask);
        st_d   = st_q;
        if (restart) begin
            st_d.pre = '0;
        end else if (tick_en) begin
            st_d.pre = strobe ? '0 : st_q.pre + INC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             strobe,
    output logic             expire,
    output stage_e           stage_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        stage_e           stage;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      running;

    always_comb begin
        running = (st_q.stage == ST_ONE) || (st_q.stage == ST_TWO);
        expire  = strobe && running && !load && (st_q.cnt == CNT_ONE);
        st_d    = st_q;
        if (load) begin
            st_d.cnt   = load_val;
            st_d.stage = (load_val != '0) ? ST_ONE : ST_IDLE;
        end else if (strobe && running) begin
            if (expire) begin
                st_d.cnt   = reload_val;
                st_d.stage = (st_q.stage == ST_ONE) ? ST_TWO : ST_DONE;
            end else begin
                st_d.cnt = st_q.cnt - CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, stage: ST_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    assign stage_o = st_q.stage;
    assign cnt_o   = st_q.cnt;

endmodule

// File: rtl/wdog_flags.sv
module wdog_flags
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              expire,
    input  stage_e            stage,
    input  act_e              act_first,
    input  act_e              act_second,
    input  logic              clr_wr,
    input  logic              clr_ovf_sel,
    output logic [FLAG_W-1:0] flags_o,
    output logic              rst_pulse_o
);

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              rst_p;
    } flag_state_t;

    flag_state_t st_d, st_q;
    act_e        act_now;

    always_comb begin
        act_now = (stage == ST_ONE) ? act_first : act_second;
        st_d    = st_q;
        // clear rules first, so a same-cycle event overrides them
        if (clr_wr) begin
            if (clr_ovf_sel) begin
                st_d.flags[FLAG_OVF] = 1'b0;
            end else begin
                st_d.flags[FLAG_RST:FLAG_IRQ] = '0;
            end
        end
        st_d.rst_p = 1'b0;
        if (expire) begin
            if (stage == ST_ONE) begin
                st_d.flags[FLAG_OVF] = 1'b1;
            end
            unique case (act_now)
                ACT_IRQ:  st_d.flags[FLAG_IRQ] = 1'b1;
                ACT_SMI:  st_d.flags[FLAG_SMI] = 1'b1;
                ACT_RST: begin
                    st_d.flags[FLAG_RST] = 1'b1;
                    st_d.rst_p           = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o     = st_q.flags;
    assign rst_pulse_o = st_q.rst_p;

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRES_MAX = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              smi_o,
    output logic              sys_rst_o,
    output logic              slow_clk_off_o
);

    localparam int PRES_W = 4;
    localparam logic [PRES_W-1:0] PRES_LIMIT = PRES_W'(PRES_MAX);

    typedef struct packed {
        logic [CNT_W-1:0]  timeout;
        logic [DATA_W-1:0] cfg;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              wr_timeout, wr_config, wr_status;
    logic              tick_gated, strobe, expire_w;
    stage_e            stage_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [FLAG_W-1:0] flags_w;
    logic [PRES_W-1:0] pres_w;
    logic [DATA_W-1:0] cfg_new;

    always_comb begin
        wr_timeout = reg_wen && (int'(reg_addr) == ADDR_TIMEOUT);
        wr_config  = reg_wen && (int'(reg_addr) == ADDR_CONFIG);
        wr_status  = reg_wen && (int'(reg_addr) == ADDR_STATUS);

        cfg_new = reg_wdata;
        if (reg_wdata[CFG_PRES_LO +: PRES_W] > PRES_LIMIT) begin
            cfg_new[CFG_PRES_LO +: PRES_W] = PRES_LIMIT;
        end

        regs_d = regs_q;
        if (wr_timeout) begin
            regs_d.timeout = reg_wdata[CNT_W-1:0];
        end
        if (wr_config) begin
            regs_d.cfg = cfg_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pres_w     = regs_q.cfg[CFG_PRES_LO +: PRES_W];
    assign tick_gated = tick_in && !regs_q.cfg[CFG_PD_BIT];

    wdog_prescaler #(
        .PRES_MAX (PRES_MAX),
        .PRES_W   (PRES_W)
    ) u_pres (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_gated),
        .restart (wr_timeout),
        .pres    (pres_w),
        .strobe  (strobe)
    );

    wdog_countdown #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_timeout),
        .load_val   (reg_wdata[CNT_W-1:0]),
        .reload_val (regs_q.timeout),
        .strobe     (strobe),
        .expire     (expire_w),
        .stage_o    (stage_w),
        .cnt_o      (cnt_w)
    );

    wdog_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire_w),
        .stage       (stage_w),
        .act_first   (act_e'(regs_q.cfg[CFG_ACT1_LO +: 2])),
        .act_second  (act_e'(regs_q.cfg[CFG_ACT2_LO +: 2])),
        .clr_wr      (wr_status),
        .clr_ovf_sel (reg_wdata[FLAG_OVF]),
        .flags_o     (flags_w),
        .rst_pulse_o (sys_rst_o)
    );

    always_comb begin
        unique case (int'(reg_addr))
            ADDR_TIMEOUT: reg_rdata = DATA_W'(regs_q.timeout);
            ADDR_CONFIG:  reg_rdata = regs_q.cfg;
            ADDR_STATUS:  reg_rdata = DATA_W'(flags_w);
            default:      reg_rdata = '0;
        endcase
    end

    assign irq_o          = flags_w[FLAG_IRQ];
    assign smi_o          = flags_w[FLAG_SMI];
    assign slow_clk_off_o = regs_q.cfg[CFG_PD_BIT];

endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int PRES_MAX = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wen,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_o,
    input logic              sys_rst_o,
    input logic              slow_clk_off_o,
    input logic              expire,
    input stage_e            stage,
    input logic [CNT_W-1:0]  cnt,
    input logic [FLAG_W-1:0] flags,
    input logic [DATA_W-1:0] cfg
);

    logic wr_to, wr_cfg, wr_st;
    assign wr_to  = reg_wen && (int'(reg_addr) == ADDR_TIMEOUT);
    assign wr_cfg = reg_wen && (int'(reg_addr) == ADDR_CONFIG);
    assign wr_st  = reg_wen && (int'(reg_addr) == ADDR_STATUS);

    assert_timeout_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_to |=> (cnt == $past(reg_wdata[CNT_W-1:0])));

    assert_pres_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cfg && (int'(reg_wdata[3:0]) > PRES_MAX)) |=> (int'(cfg[3:0]) == PRES_MAX));

    assert_tick_off_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_clk_off_o && !wr_to) |=> $stable(cnt));

    assert_ovf_on_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && stage == ST_ONE) |=> flags[FLAG_OVF]);

    assert_halt_after_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && stage == ST_TWO && !wr_to) |=> (stage == ST_DONE));

    assert_rst_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> !sys_rst_o);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_st && !reg_wdata[FLAG_OVF])) |=> irq_o);

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && stage == ST_ONE && wr_st && reg_wdata[FLAG_OVF]) |=> flags[FLAG_OVF]);

endmodule

bind wdog_two_stage wdog_two_stage_chk #(
    .CNT_W    (CNT_W),
    .PRES_MAX (PRES_MAX)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wen        (reg_wen),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .irq_o          (irq_o),
    .sys_rst_o      (sys_rst_o),
    .slow_clk_off_o (slow_clk_off_o),
    .expire         (expire_w),
    .stage          (stage_w),
    .cnt            (cnt_w),
    .flags          (flags_w),
    .cfg            (regs_q.cfg)
);

// File: tb/tb_wdog_two_stage.sv
module tb_wdog_two_stage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        reg_wen = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq_o, smi_o, sys_rst_o, slow_clk_off_o;

    always #4 clk = ~clk;

    wdog_two_stage dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_in        (tick_in),
        .reg_wen        (reg_wen),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .irq_o          (irq_o),
        .smi_o          (smi_o),
        .sys_rst_o      (sys_rst_o),
        .slow_clk_off_o (slow_clk_off_o)
    );

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int rst_seen = 0;
    bit tick_on = 0;
    bit done = 0;

    // behavioural reference state
    int m_to = 0, m_cfg = 0, m_pre = 0, m_cnt = 0, m_stage = 0, m_sts = 0, m_rst = 0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_to = 0; m_cfg = 0; m_pre = 0; m_cnt = 0; m_stage = 0; m_sts = 0; m_rst = 0;
        end else begin
            int pres, mask, act, n_sts, n_pre, n_cnt, n_stage, v;
            bit tg, strobe, wto, wcfg, wst, run, exp;
            pres   = m_cfg & 15;
            mask   = (1 << pres) - 1;
            tg     = tick_in && !((m_cfg >> 8) & 1);
            strobe = tg && (m_pre >= mask);
            wto    = reg_wen && reg_addr == 2'd0;
            wcfg   = reg_wen && reg_addr == 2'd1;
            wst    = reg_wen && reg_addr == 2'd2;
            run    = (m_stage == 1) || (m_stage == 2);
            exp    = strobe && run && (m_cnt == 1) && !wto;
            act    = (m_stage == 1) ? ((m_cfg >> 4) & 3) : ((m_cfg >> 6) & 3);
            n_sts  = m_sts;
            if (wst) begin
                if (reg_wdata[0]) n_sts = n_sts & 14;
                else n_sts = n_sts & 1;
            end
            if (exp) begin
                if (m_stage == 1) n_sts = n_sts | 1;
                if (act == 1) n_sts = n_sts | 2;
                if (act == 2) n_sts = n_sts | 4;
                if (act == 3) n_sts = n_sts | 8;
            end
            n_pre = m_pre;
            if (wto) n_pre = 0;
            else if (tg) n_pre = strobe ? 0 : m_pre + 1;
            n_cnt = m_cnt; n_stage = m_stage;
            if (wto) begin
                n_cnt = int'(reg_wdata);
                n_stage = (reg_wdata != 0) ? 1 : 0;
            end else if (strobe && run) begin
                if (exp) begin
                    n_cnt = m_to;
                    n_stage = m_stage + 1;
                end else begin
                    n_cnt = m_cnt - 1;
                end
            end
            if (wcfg) begin
                v = int'(reg_wdata);
                if ((v & 15) > 13) v = (v & 32'hFFF0) | 13;
                m_cfg = v;
            end
            if (wto) m_to = int'(reg_wdata);
            m_rst = (exp && act == 3) ? 1 : 0;
            m_sts = n_sts; m_pre = n_pre; m_cnt = n_cnt; m_stage = n_stage;
        end
    end

    always @(negedge clk) begin
        int exp_rd;
        cyc++;
        if (rst_n) begin
            case (reg_addr)
                2'd0: exp_rd = m_to;
                2'd1: exp_rd = m_cfg;
                2'd2: exp_rd = m_sts;
                default: exp_rd = 0;
            endcase
            check("R2 model rdata", int'(reg_rdata), exp_rd);
            check("R8 model irq_o", int'(irq_o), (m_sts >> 1) & 1);
            check("R8 model smi_o", int'(smi_o), (m_sts >> 2) & 1);
            check("R8 model sys_rst_o", int'(sys_rst_o), m_rst);
            check("R5 model slow_clk_off_o", int'(slow_clk_off_o), (m_cfg >> 8) & 1);
            if (sys_rst_o) rst_seen++;
        end
        tick_in = tick_on;
    end

    task automatic wr(int a, int d);
        reg_wen = 1'b1; reg_addr = 2'(a); reg_wdata = 16'(d);
        @(negedge clk); #1;
        reg_wen = 1'b0;
    endtask

    task automatic rd(string tag, int a, int exp);
        reg_addr = 2'(a);
        @(negedge clk);
        check(tag, int'(reg_rdata), exp);
        #1;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd("R1 timeout after reset", 0, 0);
        rd("R1 config after reset", 1, 0);
        rd("R1 status after reset", 2, 0);
        rd("R1 addr3 after reset", 3, 0);
        check("R1 outputs after reset", int'({irq_o, smi_o, sys_rst_o, slow_clk_off_o}), 0);

        tick_on = 1;
        // R2: timeout 0 keeps the watchdog idle
        wr(1, 16'h0010);
        wr(0, 0);
        idle(30);
        rd("R2 zero timeout no expiry", 2, 0);

        // R6/R7: first stage interrupt, second stage SMI
        wr(1, 16'h0090);
        wr(0, 5);
        idle(7);
        rd("R6 first stage flags", 2, 3);
        check("R6 irq after first expiry", int'(irq_o), 1);
        check("R7 smi before second expiry", int'(smi_o), 0);
        idle(5);
        rd("R7 second stage flags", 2, 7);
        check("R7 smi after second expiry", int'(smi_o), 1);
        idle(20);
        rd("R7 halted after second stage", 2, 7);
        rd("R2 timeout readback", 0, 5);

        // R9: asymmetric clear rules
        wr(2, 16'h0001);
        rd("R9 write one clears overflow only", 2, 6);
        wr(2, 16'h00F0);
        rd("R9 write zero clears action flags", 2, 0);
        check("R8 irq low after clear", int'(irq_o), 0);
        check("R8 smi low after clear", int'(smi_o), 0);

        // R8: reset action pulse
        rst_seen = 0;
        wr(1, 16'h0030);
        wr(0, 3);
        idle(20);
        check("R8 reset pulse width", rst_seen, 1);
        rd("R6 reset action flags", 2, 9);
        wr(2, 1);
        wr(2, 0);

        // R4/R5: clamp and reserved readback
        wr(1, 16'h000E);
        rd("R4 prescaler 14 clamps", 1, 16'h000D);
        wr(1, 16'hFE0F);
        rd("R4 prescaler 15 clamps, R5 reserved kept", 1, 16'hFE0D);

        // R5: tick power-down freezes counting
        wr(1, 16'h0110);
        wr(0, 2);
        idle(30);
        rd("R5 no expiry while tick off", 2, 0);
        check("R5 power-down output", int'(slow_clk_off_o), 1);
        wr(1, 16'h0010);
        idle(6);
        check("R5 counting resumes", int'(irq_o), 1);
        wr(0, 0);
        wr(2, 1);
        wr(2, 0);

        // R3: prescaler of 4, timeout 3 -> expiry on tick 12
        wr(1, 16'h0012);
        wr(0, 3);
        idle(10);
        check("R3 no expiry before 12 ticks", int'(irq_o), 0);
        idle(4);
        check("R3 expiry after 12 ticks", int'(irq_o), 1);
        wr(0, 0);
        wr(2, 1);
        wr(2, 0);

        // R10: expiry in the same cycle as a clear of action flags
        wr(1, 16'h0010);
        wr(0, 1);
        wr(2, 0);
        rd("R10 set wins over action clear", 2, 3);
        wr(0, 0);
        wr(2, 1);
        wr(2, 0);
        // R10: expiry in the same cycle as an overflow clear
        wr(0, 1);
        wr(2, 1);
        rd("R10 set wins over overflow clear", 2, 3);
        idle(5);

        summary();
    end

endmodule